// File: doc/BRIEF.md
# Per-Pin GPIO Configuration Bank

This block is a bank of general-purpose I/O pins, each owning one 32-bit configuration word. Words sit on a 4-byte stride, so pin n answers at byte offset 4*n. A simple single-cycle bus writes and reads these words. Each word holds the pin's data bit, a 3-bit mode that selects output or one of several input flavours, a pad function select, pull control, input enable, two drive-strength fields, a Schmitt enable, an interrupt group number and a lock bit.

The bank drives the pad output and output-enable for every pin. It also exports the remaining fields as plain control bits for the pad ring and for a companion interrupt block. Pad inputs pass through a two-flop synchronizer. When a pin is not an output, a read of its word returns that synchronized level in bit 0 instead of the stored data bit. Interrupt detection, pending state and analog pad behaviour are handled elsewhere.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset every pin word reads 0x0000_000E (mode 7, input with interrupts off, pull off, GPIO function, data 0), and every pad_oe bit is 0.
- R2: A write to byte address 4*n stores wr_data ANDed with the writable mask 0x00E7_8FEF into pin n's word. Only pin n changes. Bits outside the mask always read 0.
- R3: When mode (bits 3:1) equals 1, the pin is an output, and a read returns the stored data bit in bit 0 whatever the pad level.
- R4: When mode is any value other than 1, a read returns in bit 0 the pad level through a two-flop synchronizer. A level held for three clock edges before the read is visible.
- R5: pad_oe[n] is 1 only when mode is 1 and the function select (bits 6:5) is 0. pad_out[n] always equals the stored data bit (bit 0).
- R6: Each word's fields are exported per pin: mode bits 3:1, function 6:5, pull 8:7 (0 off, 1 down, 2 strong up, 3 up), input enable 9, drive low 11:10, Schmitt 15, interrupt group 18:16, drive high 23:22.
- R7: Bit 21 is a lock. Once a pin's stored word has it set, all later writes to that pin are ignored until reset.
- R8: An access whose address bits 1:0 are not 0, or whose word index (address bits ADDR_W-1:2) is NUM_PINS or more, hits no pin. Such a read returns 0 and such a write changes nothing.
- R9: When a read and a write address the same word in one cycle, the read returns the contents from before the write, and the write is visible to the next read.
- R10: rd_data is registered. It takes the addressed word's read view on the clock edge where rd_en is 1 and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pin_mode | output | 3*NUM_PINS | Mode field per pin |
| pin_func | output | 2*NUM_PINS | Function select per pin |
| pin_pull | output | 2*NUM_PINS | Pull control per pin |
| pin_ie | output | NUM_PINS | Input enable per pin |
| pin_schmitt | output | NUM_PINS | Schmitt enable per pin |
| pin_drv_lo | output | 2*NUM_PINS | Low drive-strength field per pin |
| pin_drv_hi | output | 2*NUM_PINS | High drive-strength field per pin |
| pin_group | output | 3*NUM_PINS | Interrupt group per pin |

## Verification
Two functions can fall in one cycle: a read and a write to the same pin's word. The bench provokes this by raising rd_en and wr_en together on one address. It judges the result by requiring the old word on rd_data first and the new word on the following read. A second overlap is a write that arrives at a locked word. The bench writes such a word and then reads it back and watches pad_oe, expecting both to be unchanged.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  localparam int CFG_W       = 32;
  localparam int DATA_BIT    = 0;
  localparam int MODE_LSB    = 1;
  localparam int FUNC_LSB    = 5;
  localparam int PULL_LSB    = 7;
  localparam int IE_BIT      = 9;
  localparam int DRVL_LSB    = 10;
  localparam int SCHMITT_BIT = 15;
  localparam int GRP_LSB     = 16;
  localparam int LOCK_BIT    = 21;
  localparam int DRVH_LSB    = 22;

  localparam logic [CFG_W-1:0] RESET_WORD = 32'h0000_000E;
  localparam logic [CFG_W-1:0] WRITE_MASK = 32'h00E7_8FEF;

  typedef enum logic [2:0] {
    PM_NONE     = 3'd0,
    PM_OUTPUT   = 3'd1,
    PM_IN_HIGH  = 3'd2,
    PM_IN_LOW   = 3'd3,
    PM_IN_RISE  = 3'd4,
    PM_IN_FALL  = 3'd5,
    PM_IN_BOTH  = 3'd6,
    PM_IN_QUIET = 3'd7
  } pin_mode_e;

  // Next stored word: a hit lands only while the lock bit is clear.
  function automatic logic [CFG_W-1:0] cfg_next(input logic [CFG_W-1:0] cur,
                                                input logic hit,
                                                input logic [CFG_W-1:0] wd);
    if (hit && !cur[LOCK_BIT]) return wd & WRITE_MASK;
    return cur;
  endfunction

  function automatic logic cfg_is_output(input logic [CFG_W-1:0] cfg);
    return cfg[MODE_LSB +: 3] == PM_OUTPUT;
  endfunction

  function automatic logic cfg_drives_pad(input logic [CFG_W-1:0] cfg);
    return cfg_is_output(cfg) && (cfg[FUNC_LSB +: 2] == 2'd0);
  endfunction

  // What a read returns: inputs show the synchronized pad level in bit 0.
  function automatic logic [CFG_W-1:0] cfg_read_view(input logic [CFG_W-1:0] cfg,
                                                     input logic pad_lvl);
    logic [CFG_W-1:0] v;
    v = cfg;
    if (!cfg_is_output(cfg)) v[DATA_BIT] = pad_lvl;
    return v;
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_PINS-1:0] hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      hit[i] = en && aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
    end
  end
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             pad_lvl,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] view,
  output logic             drive_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RESET_WORD;
    else        cfg_q <= cfg_next(cfg_q, wr_hit, wr_data);
  end

  assign view     = cfg_read_view(cfg_q, pad_lvl);
  assign drive_en = cfg_drives_pad(cfg_q);
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [31:0]           rd_data,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [3*NUM_PINS-1:0] pin_mode,
  output logic [2*NUM_PINS-1:0] pin_func,
  output logic [2*NUM_PINS-1:0] pin_pull,
  output logic [NUM_PINS-1:0]   pin_ie,
  output logic [NUM_PINS-1:0]   pin_schmitt,
  output logic [2*NUM_PINS-1:0] pin_drv_lo,
  output logic [2*NUM_PINS-1:0] pin_drv_hi,
  output logic [3*NUM_PINS-1:0] pin_group
);
  localparam int FLAT_W = CFG_W * NUM_PINS;

  logic [NUM_PINS-1:0] pad_lvl;
  logic [NUM_PINS-1:0] wr_hit;
  logic [NUM_PINS-1:0] rd_hit;
  logic [FLAT_W-1:0]   cfg_flat;
  logic [FLAT_W-1:0]   view_flat;
  logic [CFG_W-1:0]    rd_next;

  gpio_pad_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_lvl)
  );

  gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_wdec (
    .en   (wr_en),
    .addr (wr_addr),
    .hit  (wr_hit)
  );

  gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rdec (
    .en   (rd_en),
    .addr (rd_addr),
    .hit  (rd_hit)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_pin_cfg u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit[g]),
      .wr_data  (wr_data),
      .pad_lvl  (pad_lvl[g]),
      .cfg_q    (cfg_flat[g*CFG_W +: CFG_W]),
      .view     (view_flat[g*CFG_W +: CFG_W]),
      .drive_en (pad_oe[g])
    );

    assign pad_out[g]          = cfg_flat[g*CFG_W + DATA_BIT];
    assign pin_mode[g*3 +: 3]  = cfg_flat[g*CFG_W + MODE_LSB +: 3];
    assign pin_func[g*2 +: 2]  = cfg_flat[g*CFG_W + FUNC_LSB +: 2];
    assign pin_pull[g*2 +: 2]  = cfg_flat[g*CFG_W + PULL_LSB +: 2];
    assign pin_ie[g]           = cfg_flat[g*CFG_W + IE_BIT];
    assign pin_schmitt[g]      = cfg_flat[g*CFG_W + SCHMITT_BIT];
    assign pin_drv_lo[g*2 +: 2] = cfg_flat[g*CFG_W + DRVL_LSB +: 2];
    assign pin_drv_hi[g*2 +: 2] = cfg_flat[g*CFG_W + DRVH_LSB +: 2];
    assign pin_group[g*3 +: 3] = cfg_flat[g*CFG_W + GRP_LSB +: 3];
  end

  // Read hits are one-hot or empty, so an OR tree is the mux.
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rd_hit[i]) rd_next = rd_next | view_flat[i*CFG_W +: CFG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic                        rd_en,
  input logic [31:0]                 rd_data,
  input logic [NUM_PINS-1:0]         pad_oe,
  input logic [3*NUM_PINS-1:0]       pin_mode,
  input logic [NUM_PINS-1:0]         wr_hit,
  input logic [CFG_W*NUM_PINS-1:0]   cfg_flat
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

  logic wr_miss;
  assign wr_miss = (wr_addr[1:0] != 2'b00) || (wr_addr[ADDR_W-1:2] > LAST_IDX);

  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R2

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((rd_data & ~WRITE_MASK) == 32'd0)); // R2

  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_miss) |-> (wr_hit == '0)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flat[g*CFG_W + LOCK_BIT] |=> $stable(cfg_flat[g*CFG_W +: CFG_W])); // R7

    AST_OE_NEEDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[g] |-> (pin_mode[g*3 +: 3] == 3'd1)); // R5

    AST_NO_HIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[g] |=> $stable(cfg_flat[g*CFG_W +: CFG_W])); // R8
  end
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .pad_oe   (pad_oe),
  .pin_mode (pin_mode),
  .wr_hit   (wr_hit),
  .cfg_flat (cfg_flat)
);

// File: tb/gpio_cfg_bank_tb.sv
`timescale 1ns/1ps
module gpio_cfg_bank_tb;
  localparam int NP = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pin_ie, pin_schmitt;
  logic [3*NP-1:0] pin_mode, pin_group;
  logic [2*NP-1:0] pin_func, pin_pull, pin_drv_lo, pin_drv_hi;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_cfg_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_mode(pin_mode), .pin_func(pin_func),
    .pin_pull(pin_pull), .pin_ie(pin_ie), .pin_schmitt(pin_schmitt),
    .pin_drv_lo(pin_drv_lo), .pin_drv_hi(pin_drv_hi), .pin_group(pin_group)
  );

  // {expected pad_oe, pin, write word, expected read word}
  localparam logic [72:0] VEC [6] = '{
    {1'b1, 8'd0, 32'h0000_0003, 32'h0000_0003},
    {1'b0, 8'd1, 32'h0000_0022, 32'h0000_0022},
    {1'b0, 8'd2, 32'hFFDF_FFFF, 32'h00C7_8FEE},
    {1'b0, 8'd3, 32'h0000_0005, 32'h0000_0004},
    {1'b1, 8'd4, 32'h0000_0002, 32'h0000_0002},
    {1'b1, 8'd5, 32'h0045_0C83, 32'h0045_0C83}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset word and no pad driven
    for (int p = 0; p < NP; p++) begin
      do_read(AW'(4 * p), r);
      chk("R1 reset word", r, 32'h0000_000E);
    end
    chk("R1 reset pad_oe", 32'(pad_oe), 32'h0);

    // Table: R2 masking, R3 output read, R4 input read (pad low), R5 oe
    for (int k = 0; k < 6; k++) begin
      do_write(AW'(4 * VEC[k][71:64]), VEC[k][63:32]);
      do_read(AW'(4 * VEC[k][71:64]), r);
      chk("R2 table readback", r, VEC[k][31:0]);
      chk("R5 table pad_oe", 32'(pad_oe[VEC[k][66:64]]), 32'(VEC[k][72]));
    end

    // R5: pad_out follows data bit even when not driving
    chk("R5 pad_out pin0", 32'(pad_out[0]), 32'h1);
    chk("R5 pad_out pin2", 32'(pad_out[2]), 32'h1);
    chk("R5 pad_out pin4", 32'(pad_out[4]), 32'h0);

    // R6: exported fields
    chk("R6 pin5 pull", 32'(pin_pull[11:10]), 32'd1);
    chk("R6 pin5 drv_lo", 32'(pin_drv_lo[11:10]), 32'd3);
    chk("R6 pin5 drv_hi", 32'(pin_drv_hi[11:10]), 32'd1);
    chk("R6 pin5 group", 32'(pin_group[17:15]), 32'd5);
    chk("R6 pin5 mode", 32'(pin_mode[17:15]), 32'd1);
    chk("R6 pin2 func", 32'(pin_func[5:4]), 32'd3);
    chk("R6 pin2 ie schmitt", {30'd0, pin_ie[2], pin_schmitt[2]}, 32'd3);
    chk("R6 pin2 pull drv_hi group", {24'd0, pin_pull[5:4], pin_drv_hi[5:4], 1'b0, pin_group[8:6]}, 32'hF7);

    // R4: input pin shows synchronized pad level
    @(negedge clk); pad_in[3] = 1'b1; pad_in[4] = 1'b1;
    repeat (3) @(negedge clk);
    do_read(AW'(12), r);
    chk("R4 input sees pad high", r, 32'h0000_0005);
    // R3: output pin ignores pad
    do_read(AW'(16), r);
    chk("R3 output ignores pad", r, 32'h0000_0002);

    // R9: same-cycle read and write
    do_write(AW'(24), 32'h0000_0003);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(24); wr_en = 1'b1; wr_addr = AW'(24); wr_data = 32'h0000_0002;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R9 read returns old word", rd_data, 32'h0000_0003);
    do_read(AW'(24), r);
    chk("R9 next read returns new word", r, 32'h0000_0002);

    // R10: rd_data holds without rd_en, even across a write
    do_write(AW'(24), 32'h0000_0003);
    repeat (2) @(negedge clk);
    chk("R10 rd_data holds", rd_data, 32'h0000_0002);

    // R8: out-of-range and misaligned accesses
    do_write(AW'(4 * 20), 32'h0000_0003);
    do_read(AW'(4 * 20), r);
    chk("R8 out-of-range read", r, 32'h0);
    do_write(AW'(25), 32'h0000_0000);
    do_read(AW'(24), r);
    chk("R8 misaligned write ignored", r, 32'h0000_0003);
    do_read(AW'(25), r);
    chk("R8 misaligned read zero", r, 32'h0);
    do_read(AW'(0), r);
    chk("R8 pin0 untouched", r, 32'h0000_0003);

    // R7: lock
    do_write(AW'(28), 32'h0020_0003);
    do_read(AW'(28), r);
    chk("R7 locked word stored", r, 32'h0020_0003);
    do_write(AW'(28), 32'h0000_000E);
    do_read(AW'(28), r);
    chk("R7 write ignored when locked", r, 32'h0020_0003);
    chk("R7 pad_oe kept", 32'(pad_oe[7]), 32'h1);

    // R1/R7: reset clears lock and restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
    do_read(AW'(28), r);
    chk("R7 reset clears lock", r, 32'h0000_000E);
    do_write(AW'(28), 32'h0000_0003);
    do_read(AW'(28), r);
    chk("R7 writable after reset", r, 32'h0000_0003);

    summary();
    $finish;
  end
endmodule